// File: doc/BRIEF.md
# Start-Up Masked Pipeline with Running Sum

This block is a fixed-latency datapath pipeline whose internal stage registers carry no reset. That saves area and keeps the reset network small, but after power-up or a reset those stages hold unknown values until fresh data has pushed them out. A small control section stops those values from ever reaching downstream logic. The output register and the controller are the only state on the data path that takes the reset.

A reset loads a countdown and sets a hold flag. While the flag is set, the output register is held at zero, and that zero includes the valid bit. The countdown runs once reset is released. When it reaches zero the flag drops. By then every reset-less stage holds data that entered after the release, so the first beat that reaches the output is a real one.

The block also has one feedback loop: a running sum of the valid output beats. Its accumulator register is the single resettable element in that loop. It is held at zero for the whole hold interval, so the loop starts from a known state without resetting anything else.

Top module: `masked_pipe`

## Requirements
- R1: Outside the hold interval, `out_vld` and `out_dat` equal the `in_vld`/`in_dat` pair sampled exactly DEPTH+1 rising edges earlier (DEPTH reset-less stages plus the output register).
- R2: On every edge that samples `rst` high, and on every edge while the hold flag is set, the output register is loaded with `out_vld`=0 and `out_dat`=0. The result is visible right after that edge.
- R3: After the last edge with `rst` high, the outputs stay zero for DEPTH more edges. The first unmasked load happens on edge DEPTH+1 after it, and that load carries the beat sampled on the first edge with `rst` low.
- R4: The hold flag is cleared by a countdown. Reset presets the countdown to DEPTH. It steps down once per clock while `rst` is low and stops at zero. The flag is set exactly while the count is nonzero.
- R5: Beats presented on edges that sample `rst` high never appear at the outputs, whatever their valid bit.
- R6: `out_sum` is zero after any edge in the hold interval. After any other edge it equals its previous value plus the `out_dat` loaded on that edge when `out_vld` is 1, and it is unchanged otherwise.
- R7: `out_sum` is ACC_W bits wide and wraps modulo 2^ACC_W.
- R8: `out_dat` is zero whenever `out_vld` is 0.
- R9: A reset held for a single clock is enough to bring every output to a known state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; starts the hold interval |
| in_vld | input | 1 | Input beat valid |
| in_dat | input | DATA_W | Input beat data |
| out_vld | output | 1 | Output beat valid, low during the hold interval |
| out_dat | output | DATA_W | Output beat data, zero when not valid |
| out_sum | output | ACC_W | Running sum of valid output beats |

## Verification
The bench drives the pipeline with five patterns. A garbage stream with valid high during reset shows that reset-time beats are discarded. A continuous ramp right after release pins the exact edge of the first unmasked beat. A sparse valid pattern separates the latency of the valid bit from the latency of the data and shows the sum holding on idle beats. A one-cycle reset in the middle of a stream checks that in-flight beats are dropped and the sum restarts. A long run of all-ones data drives the accumulator through a wrap. Every cycle is compared against a model that delays the input by DEPTH+1 edges and blanks any edge that lies within DEPTH edges of a reset.

// File: rtl/masked_pipe_pkg.sv
package masked_pipe_pkg;

    localparam int DEF_DATA_W = 16;
    localparam int DEF_DEPTH  = 4;
    localparam int DEF_ACC_W  = 24;

    // hold flag of the flush controller
    typedef enum logic {
        GATE_PASS = 1'b0,
        GATE_HOLD = 1'b1
    } gate_e;

    // bits needed to hold a count from 0 up to max_val
    function automatic int count_bits(input int max_val);
        int w;
        w = 1;
        while ((1 << w) <= max_val) w++;
        return w;
    endfunction

endpackage

// File: rtl/mp_stage_chain.sv
module mp_stage_chain #(
    parameter int DATA_W = masked_pipe_pkg::DEF_DATA_W,
    parameter int DEPTH  = masked_pipe_pkg::DEF_DEPTH
) (
    input  logic              clk,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_dat,
    output logic              tail_vld,
    output logic [DATA_W-1:0] tail_dat
);
    // reset-less shift stages: contents are unknown until flushed
    logic              vld_q [DEPTH];
    logic [DATA_W-1:0] dat_q [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
                vld_q[s] <= in_vld;
                dat_q[s] <= in_dat;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                vld_q[s] <= vld_q[s-1];
                dat_q[s] <= dat_q[s-1];
            end
        end
    end

    assign tail_vld = vld_q[DEPTH-1];
    assign tail_dat = dat_q[DEPTH-1];

endmodule

// File: rtl/mp_flush_ctrl.sv
module mp_flush_ctrl
    import masked_pipe_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH
) (
    input  logic clk,
    input  logic rst,
    output logic hold
);
    localparam int CNT_W = count_bits(DEPTH);
    localparam logic [CNT_W-1:0] PRESET = CNT_W'(DEPTH);

    logic [CNT_W-1:0] cnt_q;
    gate_e            gate_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= PRESET;
            gate_q <= GATE_HOLD;
        end else begin
            if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            if (cnt_q <= CNT_W'(1)) gate_q <= GATE_PASS;
        end
    end

    assign hold = (gate_q == GATE_HOLD);

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= PRESET) else $error("count above preset"); // R4
    AST_CNT_STEPS_DOWN: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)) else $error("count did not step"); // R4
    AST_PASS_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (gate_q == GATE_PASS) == (cnt_q == '0)) else $error("flag and count disagree"); // R4

endmodule

// File: rtl/mp_accum.sv
module mp_accum #(
    parameter int DATA_W = masked_pipe_pkg::DEF_DATA_W,
    parameter int ACC_W  = masked_pipe_pkg::DEF_ACC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              add_en,
    input  logic [DATA_W-1:0] add_val,
    output logic [ACC_W-1:0]  acc
);
    logic [ACC_W-1:0] acc_q;

    // the only resettable element of the feedback loop
    always_ff @(posedge clk) begin
        if (clr)         acc_q <= '0;
        else if (add_en) acc_q <= acc_q + ACC_W'(add_val);
    end

    assign acc = acc_q;

    AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc_q == '0)) else $error("sum not cleared"); // R6
    AST_ACC_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!clr && !add_en) |=> $stable(acc_q)) else $error("sum moved while idle"); // R6

endmodule

// File: rtl/masked_pipe.sv
module masked_pipe
    import masked_pipe_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int DEPTH  = DEF_DEPTH,
    parameter int ACC_W  = DEF_ACC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_dat,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_dat,
    output logic [ACC_W-1:0]  out_sum
);
    logic              tail_vld;
    logic [DATA_W-1:0] tail_dat;
    logic              hold;
    logic              blank;
    logic              take;
    logic              vld_q;
    logic [DATA_W-1:0] dat_q;

    mp_stage_chain #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chain (
        .clk      (clk),
        .in_vld   (in_vld),
        .in_dat   (in_dat),
        .tail_vld (tail_vld),
        .tail_dat (tail_dat)
    );

    mp_flush_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .hold (hold)
    );

    assign blank = rst | hold;
    assign take  = tail_vld & ~hold;

    // resettable output register, cleared for the whole hold interval
    always_ff @(posedge clk) begin
        if (blank) begin
            vld_q <= 1'b0;
            dat_q <= '0;
        end else begin
            vld_q <= take;
            dat_q <= take ? tail_dat : '0;
        end
    end

    mp_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .clr     (blank),
        .add_en  (take),
        .add_val (tail_dat),
        .acc     (out_sum)
    );

    assign out_vld = vld_q;
    assign out_dat = dat_q;

    AST_MASKED_OUT_QUIET: assert property (@(posedge clk) disable iff (rst)
        hold |=> (!out_vld && out_dat == '0)) else $error("output leaked while held"); // R2
    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        !out_vld |-> (out_dat == '0)) else $error("data nonzero while invalid"); // R8
    AST_SUM_ZERO_WHEN_HELD: assert property (@(posedge clk) disable iff (rst)
        hold |=> (out_sum == '0)) else $error("sum nonzero while held"); // R6

endmodule

// File: tb/test_masked_pipe.sv
module test_masked_pipe;
    localparam int DW    = 16;
    localparam int DEPTH = 4;
    localparam int AW    = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_vld = 1'b0;
    logic [DW-1:0] in_dat = '0;
    logic          out_vld;
    logic [DW-1:0] out_dat;
    logic [AW-1:0] out_sum;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    masked_pipe #(.DATA_W(DW), .DEPTH(DEPTH), .ACC_W(AW)) i_masked_pipe (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_dat(in_dat),
        .out_vld(out_vld), .out_dat(out_dat), .out_sum(out_sum)
    );

    // reference: input delayed DEPTH+1 edges, blanked within DEPTH edges of a reset
    logic          mv [0:DEPTH];
    logic [DW-1:0] md [0:DEPTH];
    int            edge_no  = 0;
    int            last_rst = -1000;
    logic          exp_vld  = 1'b0;
    logic [DW-1:0] exp_dat  = '0;
    logic [AW-1:0] exp_sum  = '0;
    logic          exp_mask = 1'b1;

    initial for (int i = 0; i <= DEPTH; i++) begin mv[i] = 1'b0; md[i] = '0; end

    always @(posedge clk) begin
        for (int i = DEPTH; i > 0; i--) begin mv[i] = mv[i-1]; md[i] = md[i-1]; end
        mv[0] = in_vld;
        md[0] = in_dat;
        if (rst) last_rst = edge_no;
        exp_mask = (edge_no - last_rst) <= DEPTH;
        exp_vld  = !exp_mask && mv[DEPTH];
        exp_dat  = exp_vld ? md[DEPTH] : '0;
        if (exp_mask)     exp_sum = '0;
        else if (exp_vld) exp_sum = exp_sum + AW'(exp_dat);
        edge_no++;
    end

    task automatic check(input string tag, input logic ok, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // drive one beat, let one edge pass, compare everything against the model
    task automatic step(input logic r, input logic v, input logic [DW-1:0] d, input string tag);
        rst = r; in_vld = v; in_dat = d;
        @(negedge clk);
        check(tag, !$isunknown({out_vld, out_dat}) && out_vld === exp_vld && out_dat === exp_dat,
              "out vld/dat", {out_vld, out_dat}, {exp_vld, exp_dat});
        check(tag == "R7" ? "R7" : "R6", !$isunknown(out_sum) && out_sum === exp_sum,
              "out_sum", out_sum, exp_sum);
        check("R8", out_vld || out_dat == '0, "idle data", out_dat, 0);
    endtask

    task automatic t_reset_garbage;
        @(negedge clk);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, DW'(16'hBAD0 + i), "R2");
        check("R2", out_vld === 1'b0 && out_dat === '0 && out_sum === '0, "reset state",
              {out_vld, out_dat, out_sum}, 0);
    endtask

    task automatic t_flush_ramp;
        int first_at = -1;
        logic [DW-1:0] first_dat = '0;
        // garbage from reset must not show (R5), first beat on edge DEPTH+1 (R3)
        for (int i = 1; i <= 2 * DEPTH + 4; i++) begin
            step(1'b0, 1'b1, DW'(16'h0100 + i), i <= DEPTH ? "R3" : "R1");
            if (out_vld && first_at < 0) begin first_at = i; first_dat = out_dat; end
            check("R5", (out_dat & 16'hFFF0) != 16'hBAD0, "reset beat leaked", out_dat, 0);
        end
        check("R3", first_at == DEPTH + 1, "first valid edge", first_at, DEPTH + 1);
        check("R3", first_dat == DW'(16'h0101), "first valid data", first_dat, 16'h0101);
    endtask

    task automatic t_sparse;
        for (int i = 0; i < 24; i++)
            step(1'b0, (i % 3) != 1, DW'(i * 7 + 3), "R1");
    endtask

    task automatic t_mid_reset;
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, DW'(16'h2000 + i), "R1");
        step(1'b1, 1'b1, DW'(16'h2FFF), "R9");
        check("R9", out_vld === 1'b0 && out_sum === '0, "one-cycle reset clears", {out_vld, out_sum}, 0);
        for (int i = 0; i < DEPTH + 6; i++) step(1'b0, 1'b1, DW'(16'h3000 + i), i < DEPTH ? "R3" : "R9");
    endtask

    task automatic t_wrap;
        logic wrapped = 1'b0;
        logic [AW-1:0] prev;
        for (int i = 0; i < 270 + DEPTH; i++) begin
            prev = out_sum;
            step(1'b0, 1'b1, DW'(16'hFFFF), "R7");
            if (out_sum < prev) wrapped = 1'b1;
        end
        check("R7", wrapped, "sum wrapped", wrapped, 1);
    endtask

    initial begin
        t_reset_garbage();
        t_flush_ramp();
        t_sparse();
        t_mid_reset();
        t_wrap();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule